// File: doc/BRIEF.md
# Armed Double-Buffered Cursor Register Bank

This block holds the control registers of a cursor plane in two copies. Software writes land in a pending copy. The active copy, which drives the cursor hardware, is refreshed from the pending copy only on a start-of-vertical-blank pulse, and only when an arm flag is set. The bank acts as a mailbox: any number of writes may arrive within one frame, and only the pending contents present at the next vblank start are taken over.

The arm flag is set by a write to the base-address register and cleared by a write to any other register in the bank. A disarming write placed just before a vblank start, followed by the arming write just after it, therefore suppresses that latch. If the pattern keeps straddling vblank starts, the active copy stays frozen for as many frames as it lasts. Each successful latch raises a one-cycle pulse and advances a wrapping event counter.

There are four 32-bit registers, chosen by a 2-bit word address: 0 control, 1 position, 2 size, 3 base (the arming register). The active copy leaves the block as one flat bus, with register k at bits [32k+31:32k].

Top module: `cur_shadow_bank`

## Requirements
- R1: After reset `armed`=0, `latched`=0, `latch_count`=0, and both copies hold the defaults control=0x00000000, position=0x00000000, size=0x00200020, base=0x00100000.
- R2: A write to address 3 (base) sets `armed` from the next cycle onward.
- R3: A write to address 0, 1 or 2 clears `armed` from the next cycle onward, even when an update was already armed.
- R4: A `vblank_start` cycle with `armed` set copies all four pending registers to the active copy in one edge, clears `armed` (unless an arming write comes in the same cycle), pulses `latched` high for exactly one cycle and increments `latch_count` by one.
- R5: A `vblank_start` cycle with `armed` clear leaves the active copy and `latch_count` unchanged and raises no `latched` pulse.
- R6: Several writes to one register within a frame are a mailbox: only the last value before the vblank start is latched.
- R7: A disarming write before a vblank start followed by the arming write after it latches nothing at that vblank. Repeating the pattern keeps the active copy frozen for every affected frame.
- R8: An arming write in the same cycle as `vblank_start` goes into the pending copy and leaves `armed` set. The value is latched at the following vblank start. The current vblank uses the pending contents from before that write.
- R9: Active register values change only on a latch event. Writes alone never alter them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address of the write (3 = base, arming) |
| wr_data | input | 32 | Write data |
| vblank_start | input | 1 | One-cycle start-of-vertical-blank pulse |
| active_regs | output | 128 | Active copy, register k at bits [32k+31:32k] |
| armed | output | 1 | Arm flag |
| latched | output | 1 | One-cycle pulse after a latch |
| latch_count | output | 16 | Wrapping count of latch events |

## Verification
Idle vblanks with no arm show that a pulse alone moves nothing. A clean arm-then-vblank sequence shows that all four registers move together. Repeated writes to the same register within a frame separate mailbox behaviour from a copy-per-write design. Straddling patterns run over several consecutive frames show that a disarming write cancels a pending arm. An arming write in the same cycle as the vblank pulse shows which pending contents the latch takes and that the arm flag survives into the next frame.

// File: rtl/cur_bank_pkg.sv
package cur_bank_pkg;
  localparam int NUM_REGS = 4;
  localparam int REG_W    = 32;
  localparam int ARM_SLOT = 3;
  localparam int ADDR_W   = $clog2(NUM_REGS);

  typedef enum logic [ADDR_W-1:0] {
    SLOT_CTRL = 2'd0,
    SLOT_POS  = 2'd1,
    SLOT_SIZE = 2'd2,
    SLOT_BASE = 2'd3
  } slot_e;

  function automatic logic [REG_W-1:0] slot_default(input int idx);
    case (idx)
      2:       slot_default = 32'h0020_0020;
      3:       slot_default = 32'h0010_0000;
      default: slot_default = '0;
    endcase
  endfunction
endpackage

// File: rtl/cur_reg_slot.sv
module cur_reg_slot #(
  parameter int                W       = 32,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pend_we,
  input  logic [W-1:0] pend_d,
  input  logic         copy_en,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] act_q
);
  logic [W-1:0] pend_nxt;
  logic [W-1:0] act_nxt;

  always_comb begin
    pend_nxt = pend_q;
    act_nxt  = act_q;
    if (copy_en) act_nxt  = pend_q;
    if (pend_we) pend_nxt = pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= RST_VAL;
      act_q  <= RST_VAL;
    end else begin
      pend_q <= pend_nxt;
      act_q  <= act_nxt;
    end
  end
endmodule

// File: rtl/cur_arm_ctrl.sv
module cur_arm_ctrl #(
  parameter int ADDR_W   = 2,
  parameter int ARM_SLOT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              vblank_start,
  output logic              copy_en,
  output logic              armed,
  output logic              latched
);
  localparam logic [ADDR_W-1:0] ARM_A = ADDR_W'(ARM_SLOT);

  logic armed_nxt;
  logic latched_nxt;

  always_comb begin
    copy_en     = vblank_start && armed;
    latched_nxt = copy_en;
    armed_nxt   = armed;
    if (copy_en) armed_nxt = 1'b0;
    if (wr_en)   armed_nxt = (wr_addr == ARM_A);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      latched <= 1'b0;
    end else begin
      armed   <= armed_nxt;
      latched <= latched_nxt;
    end
  end
endmodule

// File: rtl/cur_latch_counter.sv
module cur_latch_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_nxt;

  always_comb begin
    count_nxt = count;
    if (inc) count_nxt = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end
endmodule

// File: rtl/cur_shadow_bank.sv
module cur_shadow_bank
  import cur_bank_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [REG_W-1:0]          wr_data,
  input  logic                      vblank_start,
  output logic [NUM_REGS*REG_W-1:0] active_regs,
  output logic                      armed,
  output logic                      latched,
  output logic [CNT_W-1:0]          latch_count
);
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  logic       copy_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  cur_arm_ctrl #(
    .ADDR_W   (ADDR_W),
    .ARM_SLOT (ARM_SLOT)
  ) u_arm (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .vblank_start (vblank_start),
    .copy_en      (copy_en),
    .armed        (armed),
    .latched      (latched)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
    logic             sel_we;
    logic [REG_W-1:0] pend_unused;
    assign sel_we = wr_en && (wr_addr == ADDR_W'(k));
    cur_reg_slot #(
      .W       (REG_W),
      .RST_VAL (slot_default(k))
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .pend_we (sel_we),
      .pend_d  (wr_data),
      .copy_en (copy_en),
      .pend_q  (pend_unused),
      .act_q   (active_regs[k*REG_W +: REG_W])
    );
  end

  cur_latch_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_q_n),
    .inc   (copy_en),
    .count (latch_count)
  );
endmodule

// File: rtl/cur_shadow_bank_chk.sv
module cur_shadow_bank_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 128,
  parameter int CNT_W  = 16,
  parameter int ARM_SLOT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              vblank_start,
  input logic [DATA_W-1:0] active_regs,
  input logic              armed,
  input logic              latched,
  input logic [CNT_W-1:0]  latch_count
);
  localparam logic [ADDR_W-1:0] ARM_A = ADDR_W'(ARM_SLOT);

  a_r2_arm_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ARM_A) |=> armed);

  a_r3_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != ARM_A) |=> !armed);

  a_r4_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_start && armed) |=> latched);

  a_r4_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_start && armed && !wr_en) |=> !armed);

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    latched |-> (latch_count == CNT_W'($past(latch_count) + 1'b1)));

  a_r5_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(vblank_start && armed) |=> !latched);

  a_r9_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !latched |-> $stable(active_regs));
endmodule

bind cur_shadow_bank cur_shadow_bank_chk #(
  .ADDR_W   (cur_bank_pkg::ADDR_W),
  .DATA_W   (cur_bank_pkg::NUM_REGS * cur_bank_pkg::REG_W),
  .CNT_W    (CNT_W),
  .ARM_SLOT (cur_bank_pkg::ARM_SLOT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .vblank_start (vblank_start),
  .active_regs  (active_regs),
  .armed        (armed),
  .latched      (latched),
  .latch_count  (latch_count)
);

// File: tb/tb_cur_shadow_bank.sv
module tb_cur_shadow_bank;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [1:0]   wr_addr;
  logic [31:0]  wr_data;
  logic         vblank_start;
  logic [127:0] active_regs;
  logic         armed;
  logic         latched;
  logic [15:0]  latch_count;

  cur_shadow_bank dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .vblank_start (vblank_start),
    .active_regs (active_regs), .armed (armed), .latched (latched),
    .latch_count (latch_count)
  );

  always #4 clk = ~clk;

  typedef struct { logic [127:0] regs; logic [15:0] cnt; string tag; } exp_t;
  exp_t exp_q[$];

  int errors = 0;
  int checks = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;

  logic [127:0] m_pend, m_active;
  logic         m_armed;
  logic [15:0]  m_cnt;

  localparam logic [127:0] DEFAULTS = {32'h0010_0000, 32'h0020_0020, 32'h0, 32'h0};

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, model update, expected latch pushed
  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d,
                      input logic vb, input string tag);
    bit   fire;
    exp_t e;
    wr_en = we; wr_addr = a; wr_data = d; vblank_start = vb;
    fire = vb && m_armed;
    if (fire) begin
      m_cnt    = m_cnt + 16'd1;
      m_active = m_pend;
      e.regs = m_pend; e.cnt = m_cnt; e.tag = tag;
    end
    if (we) begin
      m_pend[a*32 +: 32] = d;
      m_armed = (a == 2'd3);
    end else if (fire) begin
      m_armed = 1'b0;
    end
    @(posedge clk);
    #1;
    if (fire) exp_q.push_back(e);
    #1;
    wr_en = 1'b0; vblank_start = 1'b0;
    chk(armed == m_armed, tag, "armed", 128'(armed), 128'(m_armed));
    chk(active_regs == m_active, tag, "active_regs", active_regs, m_active);
    chk(latch_count == m_cnt, tag, "latch_count", 128'(latch_count), 128'(m_cnt));
  endtask

  // monitor: pops one expected item per latch pulse
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en) begin
        if (latched) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R5", "unexpected latched pulse", 128'(latched), 128'(0));
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(active_regs == e.regs, e.tag, "latched regs", active_regs, e.regs);
            chk(latch_count == e.cnt, e.tag, "latched count", 128'(latch_count), 128'(e.cnt));
          end
        end else if (exp_q.size() != 0) begin
          exp_t e;
          e = exp_q.pop_front();
          chk(1'b0, e.tag, "missing latched pulse", 128'(0), 128'(1));
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; vblank_start = 1'b0;
    m_pend = DEFAULTS; m_active = DEFAULTS; m_armed = 1'b0; m_cnt = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset values
    chk(armed == 1'b0, "R1", "armed", 128'(armed), 128'(0));
    chk(latched == 1'b0, "R1", "latched", 128'(latched), 128'(0));
    chk(latch_count == 16'd0, "R1", "latch_count", 128'(latch_count), 128'(0));
    chk(active_regs == DEFAULTS, "R1", "active defaults", active_regs, DEFAULTS);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    mon_en = 1'b1;

    // R5: vblank with no arm
    step(1'b0, 2'd0, 32'h0, 1'b1, "R5");
    step(1'b0, 2'd0, 32'h0, 1'b0, "R5");
    // R2 + R4: arm only base, pending defaults latched for the rest
    step(1'b1, 2'd3, 32'hA000_1000, 1'b0, "R2");
    step(1'b0, 2'd0, 32'h0, 1'b1, "R4");
    step(1'b0, 2'd0, 32'h0, 1'b0, "R4");
    step(1'b0, 2'd0, 32'h0, 1'b1, "R5");
    // R6 + R9: mailbox writes, active stays put until vblank
    step(1'b1, 2'd0, 32'h0000_0011, 1'b0, "R9");
    step(1'b1, 2'd1, 32'h0010_0010, 1'b0, "R9");
    step(1'b1, 2'd0, 32'h0000_0022, 1'b0, "R6");
    step(1'b1, 2'd2, 32'h0040_0040, 1'b0, "R6");
    step(1'b1, 2'd1, 32'h0033_0044, 1'b0, "R6");
    step(1'b1, 2'd3, 32'hB000_2000, 1'b0, "R6");
    step(1'b1, 2'd3, 32'hB000_3000, 1'b0, "R6");
    step(1'b0, 2'd0, 32'h0, 1'b0, "R9");
    step(1'b0, 2'd0, 32'h0, 1'b1, "R6");
    step(1'b0, 2'd0, 32'h0, 1'b0, "R6");
    // R3: disarm after arm, vblank latches nothing
    step(1'b1, 2'd3, 32'hC000_0000, 1'b0, "R3");
    step(1'b1, 2'd2, 32'h0008_0008, 1'b0, "R3");
    step(1'b0, 2'd0, 32'h0, 1'b1, "R3");
    // R7: straddling pattern over several frames
    for (int f = 0; f < 4; f++) begin
      step(1'b1, 2'd3, 32'hD000_0000 + 32'(f), 1'b0, "R7");
      step(1'b1, 2'd1, 32'h0100_0000 + 32'(f), 1'b0, "R7");
      step(1'b0, 2'd0, 32'h0, 1'b1, "R7");
      step(1'b1, 2'd3, 32'hD100_0000 + 32'(f), 1'b0, "R7");
      step(1'b0, 2'd0, 32'h0, 1'b0, "R7");
    end
    // the pattern stops: a clean arm latches everything
    step(1'b0, 2'd0, 32'h0, 1'b1, "R7");
    step(1'b0, 2'd0, 32'h0, 1'b0, "R7");
    // R8: arming write coincident with vblank
    step(1'b1, 2'd0, 32'h0000_0055, 1'b0, "R8");
    step(1'b1, 2'd3, 32'hE000_0000, 1'b0, "R8");
    step(1'b1, 2'd3, 32'hE100_0000, 1'b1, "R8");
    step(1'b0, 2'd0, 32'h0, 1'b0, "R8");
    step(1'b0, 2'd0, 32'h0, 1'b1, "R8");
    step(1'b0, 2'd0, 32'h0, 1'b0, "R8");
    // R8: coincident arming write with no prior arm
    step(1'b1, 2'd3, 32'hF000_0000, 1'b1, "R8");
    step(1'b0, 2'd0, 32'h0, 1'b1, "R8");
    step(1'b0, 2'd0, 32'h0, 1'b0, "R8");
    step(1'b0, 2'd0, 32'h0, 1'b0, "R4");

    chk(exp_q.size() == 0, "R4", "queue drained", 128'(exp_q.size()), 128'(0));
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule